// File: doc/BRIEF.md
# Multi-Channel Interrupt Mask Bank

This block holds the interrupt mask, control and event state for eight identical line channels that share one processor bus. Each channel counts three kinds of raw error pulse (framing-bit errors, CRC-6 errors and out-of-frame events) in free-running 8-bit counters. A counter that steps from FFh to 00h latches an event bit. The event bit passes to the interrupt line only while its mask bit is 0. The requests from all channels are ORed onto a single active-high interrupt output.

Software reaches a channel through address bits 11 to 8 and picks a register within the channel with bits 7 to 0. A select value of 1000b writes the same register in every channel in one bus cycle. A per-channel control bit gives a software reset: the channel's masks are cleared when that bit is written from 1 to 0.

Top module: `irq_mask_bank`

## Requirements
- R1: Address bits 11..8 with a value of 0 to 7 select one channel, and a write changes only that channel. The register offsets in bits 7..0 are: 00h mask (bit 0 framing, bit 1 CRC-6, bit 2 out-of-frame), 01h control (bit 0 is the soft-reset bit), 02h status (event bits in the same positions as the mask), and 03h/04h/05h the framing, CRC-6 and out-of-frame counters. Unused bits and unused offsets read as 0.
- R2: A write with address bits 11..8 equal to 1000b updates the addressed register in all eight channels in the same cycle.
- R3: A mask bit of 1 blocks its event from the interrupt output, and a mask bit of 0 lets it through.
- R4: While the synchronous active-low reset is held, all masks, control bits, counters and event bits are cleared and the interrupt output is low.
- R5: Writing the control bit from 1 to 0 clears that channel's masks in that cycle. Writing 1, holding 1, or writing 0 while the bit is already 0 leaves the masks unchanged.
- R6: Each error pulse adds one to its counter. From FFh the counter wraps to 00h and keeps counting.
- R7: A counter wrap sets its status bit on the clock edge of the wrap. The bit stays set until a read of the status register, which clears it. A wrap in the same cycle as that read leaves the bit set.
- R8: A read with select 1000b returns channel 0 and acts as a channel-0 read. Selects 9 to 15 are ignored on write and read as 0.
- R9: The interrupt output is combinational from registered state. It goes high in the cycle after the edge that makes an unmasked event bit 1, and falls after the edge that clears the event or sets its mask.
- R10: Read data is 0 whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Bus address: channel select in 11..8, register offset in 7..0 |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a status read clears on the edge that ends it |
| bus_rdata | output | 16 | Combinational read data |
| frm_err_i | input | 8 | Framing-bit error pulse, one bit per channel |
| crc_err_i | input | 8 | CRC-6 error pulse, one bit per channel |
| oof_err_i | input | 8 | Out-of-frame event pulse, one bit per channel |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
Some properties are checked on every cycle: the counter steps by one and wraps to zero, at most one channel takes a read, the falling edge of the soft-reset bit clears the masks, masks hold when no mask or control write occurs, event bits stay set between status reads, and selects above 1000b leave every channel untouched. Other behaviour can only be shown by the bench's scenarios, because it spans several operations and its outcome appears at the ports. This includes the broadcast reaching every channel, the broadcast read returning channel 0, the masking of a wrapped counter and then its release onto the interrupt line, a wrap that coincides with a status read, and reset removing a live interrupt.

// File: rtl/imb_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the interrupt mask bank.
// Assumes three event sources per channel in a fixed bit order.
package imb_pkg;
    localparam int ADDR_W    = 12;
    localparam int SEL_W     = 4;
    localparam int OFF_W     = 8;
    localparam int NUM_SRC   = 3;            // bit0 framing, bit1 CRC-6, bit2 out-of-frame
    localparam logic [SEL_W-1:0] BCAST_SEL = 4'b1000;
    localparam logic [OFF_W-1:0] OFF_MASK  = 8'h00;
    localparam logic [OFF_W-1:0] OFF_CTRL  = 8'h01;
    localparam logic [OFF_W-1:0] OFF_STAT  = 8'h02;
    localparam logic [OFF_W-1:0] OFF_CNT0  = 8'h03;
endpackage

// File: rtl/imb_bus_decode.sv
`timescale 1ns/1ps
// Module: imb_bus_decode
// Turns the shared bus address into per-channel write and read enables.
// Select 1000b writes every channel and reads channel 0; selects above
// it hit nothing. Assumes NUM_CH <= 8.
module imb_bus_decode
    import imb_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [NUM_CH-1:0]   wr_en,
    output logic [NUM_CH-1:0]   rd_en,
    output logic [OFF_W-1:0]    reg_off
);
    logic [SEL_W-1:0] sel;
    logic             bcast;

    assign sel     = bus_addr[ADDR_W-1:ADDR_W-SEL_W];
    assign reg_off = bus_addr[OFF_W-1:0];
    assign bcast   = (sel == BCAST_SEL);

    // Per-channel enables: direct hit, or the broadcast select
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dec
        logic hit;
        assign hit       = (sel == SEL_W'(ch));
        assign wr_en[ch] = bus_wr && (hit || bcast);
        if (ch == 0) begin : g_rd0
            assign rd_en[ch] = bus_rd && (hit || bcast);
        end else begin : g_rdn
            assign rd_en[ch] = bus_rd && hit;
        end
    end

    // R8: a read never touches more than one channel
    p_single_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_en));

    // R8: selects above broadcast leave every channel alone
    p_unmapped_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel > BCAST_SEL) |-> (wr_en == '0));

    // R2: a broadcast write reaches every channel
    p_bcast_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bcast) |-> (&wr_en));
endmodule

// File: rtl/imb_err_counter.sv
`timescale 1ns/1ps
// Module: imb_err_counter
// Free-running error counter with no saturation; wrap pulses for one
// cycle when an increment arrives at all-ones. Assumes inc is one cycle per event.
module imb_err_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    assign wrap = inc && (&cnt);

    // Count each pulse, rolling over at the top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: all-ones plus one lands at zero
    p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && (&cnt)) |=> (cnt == '0));

    // R6: below the top each pulse adds exactly one
    p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !(&cnt)) |=> (cnt == $past(cnt) + 1'b1));

    // R6: no pulse, no change
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt));
endmodule

// File: rtl/imb_channel.sv
`timescale 1ns/1ps
// Module: imb_channel
// One channel: three error counters, mask and control registers, sticky
// event bits and the masked request. Assumes at most one of wr_en/rd_en
// per cycle per offset, and that reg_off is valid whenever they are high.
module imb_channel
    import imb_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [OFF_W-1:0]   reg_off,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [NUM_SRC-1:0] err_pulse,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq_req
);
    logic [NUM_SRC-1:0] mask_q;
    logic               ctrl_q;
    logic [NUM_SRC-1:0] ev_q;
    logic [NUM_SRC-1:0] wrap;
    logic [CNT_W-1:0]   cnt_v [NUM_SRC];
    logic               mask_wr, ctrl_wr, soft_fall, stat_rd;

    // One counter per event source
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_cnt
        imb_err_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (err_pulse[k]),
            .cnt  (cnt_v[k]),
            .wrap (wrap[k])
        );
    end

    assign mask_wr   = wr_en && (reg_off == OFF_MASK);
    assign ctrl_wr   = wr_en && (reg_off == OFF_CTRL);
    assign stat_rd   = rd_en && (reg_off == OFF_STAT);
    assign soft_fall = ctrl_wr && ctrl_q && !wdata[0];

    // Mask register: hard reset, soft-reset falling edge, or bus write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (soft_fall) begin
            mask_q <= '0;
        end else if (mask_wr) begin
            mask_q <= wdata;
        end
    end

    // Soft-reset control bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 1'b0;
        end else if (ctrl_wr) begin
            ctrl_q <= wdata[0];
        end
    end

    // Sticky events: read clears, a same-cycle wrap wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q <= (stat_rd ? '0 : ev_q) | wrap;
        end
    end

    // Register read mux within the channel
    always_comb begin
        rdata = '0;
        case (reg_off)
            OFF_MASK: rdata = DATA_W'(mask_q);
            OFF_CTRL: rdata = DATA_W'(ctrl_q);
            OFF_STAT: rdata = DATA_W'(ev_q);
            default: begin
                for (int k = 0; k < NUM_SRC; k++) begin
                    if (reg_off == OFF_W'(OFF_CNT0 + k)) begin
                        rdata = DATA_W'(cnt_v[k]);
                    end
                end
            end
        endcase
    end

    assign irq_req = |(ev_q & ~mask_q);

    // R5: a 1-to-0 control write empties the masks
    p_soft_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        soft_fall |=> (mask_q == '0));

    // R5: masks only move on a mask or control write
    p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mask_wr || ctrl_wr) |=> $stable(mask_q));

    // R7: without a status read, no event bit drops
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

    // R7: every wrap is seen in the status, even during a read
    p_wrap_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap) |=> ((ev_q & $past(wrap)) == $past(wrap)));
endmodule

// File: rtl/irq_mask_bank.sv
`timescale 1ns/1ps
// Module: irq_mask_bank (top)
// Eight channels behind one bus: decode, per-channel state, read
// selection and the ORed interrupt. Assumes single-cycle bus strobes
// and one-cycle error pulses.
module irq_mask_bank
    import imb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_wr,
    input  logic               bus_rd,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_CH-1:0]  frm_err_i,
    input  logic [NUM_CH-1:0]  crc_err_i,
    input  logic [NUM_CH-1:0]  oof_err_i,
    output logic               irq_o
);
    logic [NUM_CH-1:0]             wr_en, rd_en, ch_irq;
    logic [OFF_W-1:0]              reg_off;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_rdata;
    logic                          unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

    imb_bus_decode #(.NUM_CH(NUM_CH)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_addr(bus_addr),
        .bus_wr  (bus_wr),
        .bus_rd  (bus_rd),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .reg_off (reg_off)
    );

    // Channel instances with their three error inputs
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        imb_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en[ch]),
            .rd_en    (rd_en[ch]),
            .reg_off  (reg_off),
            .wdata    (bus_wdata[NUM_SRC-1:0]),
            .err_pulse({oof_err_i[ch], crc_err_i[ch], frm_err_i[ch]}),
            .rdata    (ch_rdata[ch]),
            .irq_req  (ch_irq[ch])
        );
    end

    // Return data from the channel the read selected, else zero
    always_comb begin
        bus_rdata = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (rd_en[ch]) begin
                bus_rdata = ch_rdata[ch];
            end
        end
    end

    assign irq_o = |ch_irq;

    // R10: an idle bus returns zero
    p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));

    // R9: interrupt only when some channel requests
    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ch_irq != '0));
endmodule

// File: tb/sim_irq_mask_bank.sv
`timescale 1ns/100ps
module sim_irq_mask_bank;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic [NCH-1:0] frm_err_i = '0, crc_err_i = '0, oof_err_i = '0;
    logic        irq_o;

    int n_checks = 0, n_fail = 0;
    bit started = 0;

    // reference state
    int m_mask [NCH];
    int m_ctrl [NCH];
    int m_ev   [NCH];
    int m_cnt  [NCH][3];

    always #2.5 clk = ~clk;

    irq_mask_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .frm_err_i(frm_err_i), .crc_err_i(crc_err_i), .oof_err_i(oof_err_i),
        .irq_o(irq_o)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_mask[c] = 0; m_ctrl[c] = 0; m_ev[c] = 0;
                for (int k = 0; k < 3; k++) m_cnt[c][k] = 0;
            end
        end else begin
            int sel, off;
            sel = int'(bus_addr[11:8]);
            off = int'(bus_addr[7:0]);
            for (int c = 0; c < NCH; c++) begin
                int setb;
                bit pw, pr;
                bit [2:0] p;
                p = {oof_err_i[c], crc_err_i[c], frm_err_i[c]};
                setb = 0;
                for (int k = 0; k < 3; k++) begin
                    if (p[k]) begin
                        if (m_cnt[c][k] == 255) begin
                            m_cnt[c][k] = 0;
                            setb |= (1 << k);
                        end else m_cnt[c][k]++;
                    end
                end
                pw = bus_wr && (sel == c || sel == 8);
                pr = bus_rd && (sel == c || (sel == 8 && c == 0));
                if (pr && off == 2) m_ev[c] = 0;
                m_ev[c] |= setb;
                if (pw && off == 0) m_mask[c] = int'(bus_wdata[2:0]);
                if (pw && off == 1) begin
                    if (m_ctrl[c] == 1 && bus_wdata[0] == 1'b0) m_mask[c] = 0;
                    m_ctrl[c] = int'(bus_wdata[0]);
                end
            end
            started = 1;
        end
    end

    function automatic int exp_rdata();
        int sel, off, c;
        if (!bus_rd) return 0;
        sel = int'(bus_addr[11:8]);
        off = int'(bus_addr[7:0]);
        if (sel > 8) return 0;
        c = (sel == 8) ? 0 : sel;
        case (off)
            0: return m_mask[c];
            1: return m_ctrl[c];
            2: return m_ev[c];
            3, 4, 5: return m_cnt[c][off-3];
            default: return 0;
        endcase
    endfunction

    function automatic int exp_irq();
        int r = 0;
        for (int c = 0; c < NCH; c++) if ((m_ev[c] & ~m_mask[c] & 7) != 0) r = 1;
        return r;
    endfunction

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        #1.5;
        if (rst_n && started) begin
            chk(int'(irq_o), exp_irq(), "R9 irq vs model");
            chk(int'(bus_rdata), exp_rdata(), "R10 rdata vs model");
        end
    end

    task automatic idle_bus();
        @(negedge clk); #0.5;
        bus_wr = 0; bus_rd = 0; frm_err_i = '0; crc_err_i = '0; oof_err_i = '0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk); #0.5;
        bus_rd = 0; bus_wr = 1; bus_addr = a; bus_wdata = d;
        frm_err_i = '0; crc_err_i = '0; oof_err_i = '0;
    endtask

    task automatic rd(input logic [11:0] a, input int exp, input string tag);
        @(negedge clk); #0.5;
        bus_wr = 0; bus_rd = 1; bus_addr = a;
        frm_err_i = '0; crc_err_i = '0; oof_err_i = '0;
        #1;
        chk(int'(bus_rdata), exp, tag);
    endtask

    task automatic pulses(input int kind, input int c, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #0.5;
            bus_wr = 0; bus_rd = 0;
            frm_err_i = '0; crc_err_i = '0; oof_err_i = '0;
            if (kind == 0) frm_err_i[c] = 1'b1;
            else if (kind == 1) crc_err_i[c] = 1'b1;
            else oof_err_i[c] = 1'b1;
        end
        idle_bus();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #0.5; rst_n = 1;
        // R4: reset state
        rd(12'h300, 0, "R4 mask after reset");
        #0.1 chk(int'(irq_o), 0, "R4 irq after reset");
        // R1: single-channel write
        wr(12'h200, 16'h0005);
        rd(12'h200, 5, "R1 ch2 mask");
        rd(12'h100, 0, "R1 ch1 untouched");
        rd(12'h201, 0, "R1 ctrl unused bits");
        rd(12'h20F, 0, "R1 unused offset");
        // R2: broadcast
        wr(12'h800, 16'hFFF3);
        rd(12'h500, 3, "R2 ch5 broadcast");
        rd(12'h000, 3, "R2 ch0 broadcast");
        // R8: broadcast read and unmapped selects
        wr(12'h000, 16'h0006);
        rd(12'h800, 6, "R8 broadcast read is ch0");
        wr(12'hA00, 16'h0007);
        rd(12'h100, 3, "R8 unmapped write ignored");
        rd(12'hA00, 0, "R8 unmapped read zero");
        // R6: counting and wrap
        pulses(0, 4, 255);
        rd(12'h403, 255, "R6 count to FF");
        rd(12'h402, 0, "R7 no event before wrap");
        pulses(0, 4, 1);
        rd(12'h403, 0, "R6 wrap to 00");
        pulses(0, 4, 2);
        rd(12'h403, 2, "R6 keeps counting");
        // R3: masked event keeps irq low
        idle_bus(); #1;
        chk(int'(irq_o), 0, "R3 masked event");
        wr(12'h400, 16'h0002);
        idle_bus(); #1;
        chk(int'(irq_o), 1, "R3 unmasked event raises irq");
        // R7: read clears
        rd(12'h402, 1, "R7 status shows wrap");
        idle_bus(); #1;
        chk(int'(irq_o), 0, "R7 irq drops after read");
        rd(12'h402, 0, "R7 status cleared");
        // R7: wrap during status read survives
        pulses(1, 4, 255);
        @(negedge clk); #0.5;
        bus_rd = 1; bus_addr = 12'h402; crc_err_i[4] = 1'b1;
        #1 chk(int'(bus_rdata), 0, "R7 read during wrap");
        rd(12'h402, 2, "R7 same-cycle wrap kept");
        // R5: soft reset on falling edge only
        wr(12'h600, 16'h0007);
        wr(12'h601, 16'h0001);
        idle_bus(); idle_bus(); idle_bus();
        rd(12'h600, 7, "R5 hold at 1 keeps masks");
        wr(12'h601, 16'h0000);
        rd(12'h600, 0, "R5 falling edge clears");
        wr(12'h600, 16'h0005);
        wr(12'h601, 16'h0000);
        rd(12'h600, 5, "R5 0 to 0 keeps masks");
        // R9: out-of-frame wrap on ch6, then unmask
        pulses(2, 6, 256);
        idle_bus(); #1;
        chk(int'(irq_o), 0, "R3 oof masked");
        wr(12'h600, 16'h0000);
        idle_bus(); #1;
        chk(int'(irq_o), 1, "R9 irq after unmask");
        // R4: reset clears live interrupt
        @(negedge clk); #0.5; rst_n = 0;
        repeat (2) @(posedge clk);
        #1 chk(int'(irq_o), 0, "R4 irq in reset");
        @(negedge clk); #0.5; rst_n = 1;
        rd(12'h605, 0, "R4 counter cleared");
        rd(12'h400, 0, "R4 mask cleared");
        idle_bus(); idle_bus();
        finish_run();
    end
endmodule